// File: doc/BRIEF.md
# Watchdog and Low-Voltage Reset Supervisor

This block supervises reset for a small microcontroller. It merges four reset causes into one internal reset: an external active-low reset pin, a power-on pulse, an undervoltage comparator, and a watchdog. The watchdog counts down from its timeout every clock. Firmware keeps it from firing with a two-write unlock: one key byte to a first feed register, then a second key byte to a second feed register. If the watchdog reaches zero, it holds the internal reset for a fixed number of cycles.

Control bits are written to a staging copy and only take effect when a valid feed commits them. This includes stopping the watchdog and disabling the undervoltage reset. Two sticky flags record a cold start and an undervoltage event, so firmware can tell the causes apart after restart. This matters because the undervoltage path resets the chip internally and leaves the external pin alone.

The port-clear output follows the internal reset. It reacts to the external pin and the power-on pulse without waiting for a clock edge.

Top module: `rst_supervisor`

## Requirements
- R1: A feed is valid when 8'hA5 is written to address 1 and the next bus write is 8'h5A to address 2. Cycles with no write in between are allowed. A valid feed reloads the watchdog to its full timeout and commits the staged control bits.
- R2: The sequence is aborted by any other write between the two feed writes, or by a wrong key value. An aborted sequence neither reloads the counter nor commits staged bits.
- R3: Address 0 is the control register: bit 2 is watchdog run and bit 4 is undervoltage-reset enable. Writes go to a staging copy. Reads return the committed bits, so a write is invisible until a valid feed.
- R4: Every reset cause restores the committed and staged control bits to run=1 and enable=1. After any reset, address 0 reads 8'h14.
- R5: With run committed, the internal reset rises exactly TIMEOUT clock edges after the edge of the last reload. It stays high for RST_CYC clock cycles.
- R6: With run committed to 0, the watchdog never resets the chip.
- R7: With the enable bit committed to 1, a high comparator input raises the internal reset from the next clock edge. The reset is released one edge after the input falls.
- R8: With the enable bit committed to 0, a high comparator input causes no reset.
- R9: Address 3 is the status register. Bit 5 (undervoltage flag) is set on every clock edge where the comparator input is high, whether or not the reset is enabled. Bit 4 (power-on flag) is set asynchronously by the power-on pulse, which also clears bit 5.
- R10: Both flags survive the watchdog and undervoltage resets. Writing 0 to a flag bit clears it; writing 1 leaves it unchanged.
- R11: Port-clear is high, with no clock edge needed, whenever the external reset is low or the power-on pulse is high. It is also high throughout any internal reset. Bus writes made during an internal reset have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| ext_rst_n | input | 1 | External reset pin, active low |
| por_pulse | input | 1 | Power-on detector pulse, active high |
| lv_detect | input | 1 | Undervoltage comparator output, active high |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| sys_rst | output | 1 | Internal chip reset, active high |
| port_clr | output | 1 | Forces port pins low while reset is active |

## Verification
The bench attacks the unlock sequence with three kinds of input: a foreign write between the two key writes, a wrong first key, and a read or idle cycle between the keys. A design that matched keys without tracking adjacency would commit on the first. A design that treated reads as interruptions would reject the third. It measures the watchdog's expiry edge and reset width cycle by cycle, so an off-by-one counter or stretch shows up at once. It checks that an undervoltage flag raised with the reset disabled survives a later watchdog reset and a clearing write issued during that reset. It also checks that the power-on pulse and the reset pin raise port-clear between clock edges, which a synchronous implementation would miss.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

  localparam int REG_CTRL   = 0;
  localparam int REG_FEED_A = 1;
  localparam int REG_FEED_B = 2;
  localparam int REG_STATUS = 3;

  localparam logic [7:0] FEED_KEY_A = 8'hA5;
  localparam logic [7:0] FEED_KEY_B = 8'h5A;

  localparam int BIT_WD_RUN = 2;
  localparam int BIT_LV_EN  = 4;
  localparam int BIT_POR    = 4;
  localparam int BIT_UV     = 5;

  typedef struct packed {
    logic wd_run;
    logic lv_en;
  } ctrl_t;

  localparam ctrl_t CTRL_DEFAULT = '{wd_run: 1'b1, lv_en: 1'b1};

  typedef struct packed {
    logic armed;
    logic ok;
  } feed_step_t;

  // One bus write applied to the unlock tracker.
  function automatic feed_step_t feed_step(logic armed, logic is_a, logic is_b,
                                           logic [7:0] data);
    feed_step_t r;
    r.ok    = armed && is_b && (data == FEED_KEY_B);
    r.armed = is_a && (data == FEED_KEY_A);
    return r;
  endfunction

  function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
    ctrl_t c;
    c.wd_run = b[BIT_WD_RUN];
    c.lv_en  = b[BIT_LV_EN];
    return c;
  endfunction

  function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
    logic [7:0] b;
    b = '0;
    b[BIT_WD_RUN] = c.wd_run;
    b[BIT_LV_EN]  = c.lv_en;
    return b;
  endfunction

  function automatic logic [7:0] status_to_byte(logic por, logic uv);
    logic [7:0] b;
    b = '0;
    b[BIT_POR] = por;
    b[BIT_UV]  = uv;
    return b;
  endfunction

  // Sticky flag: a set event wins over a write of zero; a written one does nothing.
  function automatic logic flag_next(logic cur, logic set, logic wr, logic wr_bit);
    if (set)              return 1'b1;
    else if (wr && !wr_bit) return 1'b0;
    else                  return cur;
  endfunction

endpackage

// File: rtl/rsv_feed_seq.sv
module rsv_feed_seq
  import rsv_pkg::*;
(
  input  logic       clk,
  input  logic       hard_rst,
  input  logic       sync_rst,
  input  logic       wr_en,
  input  logic       is_a,
  input  logic       is_b,
  input  logic [7:0] wdata,
  output logic       feed_ok
);

  logic       armed_q;
  feed_step_t step;

  always_comb begin
    step    = feed_step(armed_q, is_a, is_b, wdata);
    feed_ok = wr_en && step.ok;
  end

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)      armed_q <= 1'b0;
    else if (sync_rst) armed_q <= 1'b0;
    else if (wr_en)    armed_q <= step.armed;
  end

endmodule

// File: rtl/rsv_wdt.sv
module rsv_wdt #(
  parameter int TIMEOUT = 98304,
  parameter int RST_CYC = 16
) (
  input  logic                        clk,
  input  logic                        hard_rst,
  input  logic                        sync_rst,
  input  logic                        run,
  input  logic                        reload,
  output logic                        expire,
  output logic                        busy,
  output logic [$clog2(TIMEOUT)-1:0]  cnt
);

  localparam int CNT_W = $clog2(TIMEOUT);
  localparam int RS_W  = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT - 1);
  localparam logic [RS_W-1:0]  RS_LOAD  = RS_W'(RST_CYC);

  logic [RS_W-1:0] stretch_q;

  assign expire = run && (cnt == '0) && !sync_rst && !reload;
  assign busy   = (stretch_q != '0);

  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)               cnt <= CNT_FULL;
    else if (sync_rst || reload) cnt <= CNT_FULL;
    else if (run && cnt != '0)  cnt <= cnt - 1'b1;
  end

  // Reset stretcher: cleared only by the hard reset, never by its own output.
  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst)    stretch_q <= '0;
    else if (expire) stretch_q <= RS_LOAD;
    else if (busy)   stretch_q <= stretch_q - 1'b1;
  end

endmodule

// File: rtl/rsv_flags.sv
module rsv_flags
  import rsv_pkg::*;
(
  input  logic clk,
  input  logic por_pulse,
  input  logic lv_detect,
  input  logic wr_status,
  input  logic wr_por_bit,
  input  logic wr_uv_bit,
  output logic por_flag,
  output logic uv_flag
);

  always_ff @(posedge clk or posedge por_pulse) begin
    if (por_pulse) begin
      por_flag <= 1'b1;
      uv_flag  <= 1'b0;
    end else begin
      por_flag <= flag_next(por_flag, 1'b0, wr_status, wr_por_bit);
      uv_flag  <= flag_next(uv_flag, lv_detect, wr_status, wr_uv_bit);
    end
  end

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
  import rsv_pkg::*;
#(
  parameter int ADDR_W  = 2,
  parameter int TIMEOUT = 98304,
  parameter int RST_CYC = 16
) (
  input  logic              clk,
  input  logic              ext_rst_n,
  input  logic              por_pulse,
  input  logic              lv_detect,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  output logic [7:0]        bus_rdata,
  output logic              sys_rst,
  output logic              port_clr
);

  localparam int CNT_W = $clog2(TIMEOUT);

  logic             hard_rst, sync_rst, wr_en;
  logic             sel_ctrl, sel_fa, sel_fb, sel_stat;
  logic             feed_ok, wd_expire, wd_busy, lv_hit;
  logic [CNT_W-1:0] wd_cnt;
  logic             por_flag, uv_flag;
  ctrl_t            ctrl_pend, ctrl_act;

  assign hard_rst = !ext_rst_n || por_pulse;
  assign sync_rst = wd_busy || lv_hit;
  assign sys_rst  = hard_rst || sync_rst;
  assign port_clr = sys_rst;
  assign wr_en    = bus_we && !sys_rst;

  assign sel_ctrl = (bus_addr == ADDR_W'(REG_CTRL));
  assign sel_fa   = (bus_addr == ADDR_W'(REG_FEED_A));
  assign sel_fb   = (bus_addr == ADDR_W'(REG_FEED_B));
  assign sel_stat = (bus_addr == ADDR_W'(REG_STATUS));

  rsv_feed_seq u_feed (
    .clk(clk), .hard_rst(hard_rst), .sync_rst(sync_rst), .wr_en(wr_en),
    .is_a(sel_fa), .is_b(sel_fb), .wdata(bus_wdata), .feed_ok(feed_ok)
  );

  rsv_wdt #(.TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC)) u_wdt (
    .clk(clk), .hard_rst(hard_rst), .sync_rst(sync_rst), .run(ctrl_act.wd_run),
    .reload(feed_ok), .expire(wd_expire), .busy(wd_busy), .cnt(wd_cnt)
  );

  rsv_flags u_flags (
    .clk(clk), .por_pulse(por_pulse), .lv_detect(lv_detect),
    .wr_status(wr_en && sel_stat), .wr_por_bit(bus_wdata[BIT_POR]),
    .wr_uv_bit(bus_wdata[BIT_UV]), .por_flag(por_flag), .uv_flag(uv_flag)
  );

  // Staged and committed control bits.
  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) begin
      ctrl_pend <= CTRL_DEFAULT;
      ctrl_act  <= CTRL_DEFAULT;
    end else if (sync_rst) begin
      ctrl_pend <= CTRL_DEFAULT;
      ctrl_act  <= CTRL_DEFAULT;
    end else begin
      if (wr_en && sel_ctrl) ctrl_pend <= byte_to_ctrl(bus_wdata);
      if (feed_ok)           ctrl_act  <= ctrl_pend;
    end
  end

  // Undervoltage reset request; not cleared by the reset it raises.
  always_ff @(posedge clk or posedge hard_rst) begin
    if (hard_rst) lv_hit <= 1'b0;
    else          lv_hit <= lv_detect && ctrl_act.lv_en;
  end

  always_comb begin
    if (sel_ctrl)      bus_rdata = ctrl_to_byte(ctrl_act);
    else if (sel_stat) bus_rdata = status_to_byte(por_flag, uv_flag);
    else               bus_rdata = 8'h00;
  end

endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
  parameter int TIMEOUT = 98304,
  parameter int RST_CYC = 16
) (
  input logic                       clk,
  input logic                       ext_rst_n,
  input logic                       por_pulse,
  input logic                       lv_detect,
  input logic                       sys_rst,
  input logic                       port_clr,
  input logic                       feed_ok,
  input logic                       wd_expire,
  input logic                       wd_busy,
  input logic [$clog2(TIMEOUT)-1:0] wd_cnt,
  input logic                       lv_hit,
  input logic                       lv_en,
  input logic                       wd_run,
  input logic                       uv_flag
);

  logic hard;
  int   busy_len;

  assign hard = !ext_rst_n || por_pulse;

  always_ff @(posedge clk or posedge hard) begin
    if (hard)         busy_len <= 0;
    else if (wd_busy) busy_len <= busy_len + 1;
    else              busy_len <= 0;
  end

  AST_PIN_CLEARS_PORTS: assert property (@(posedge clk)
    !ext_rst_n |-> (port_clr && sys_rst)); // R11

  AST_FEED_RELOADS: assert property (@(posedge clk) disable iff (hard)
    feed_ok |=> (wd_cnt == ($clog2(TIMEOUT))'(TIMEOUT - 1))); // R1

  AST_EXPIRE_RESETS: assert property (@(posedge clk) disable iff (hard)
    wd_expire |=> (sys_rst && wd_busy)); // R5

  AST_RESET_WIDTH: assert property (@(posedge clk) disable iff (hard)
    $fell(wd_busy) |-> (busy_len == RST_CYC)); // R5

  AST_HALTED_HOLDS: assert property (@(posedge clk) disable iff (hard)
    (!wd_run && !sys_rst && !feed_ok) |=> $stable(wd_cnt)); // R6

  AST_LV_GATED: assert property (@(posedge clk) disable iff (hard)
    (lv_detect && !lv_en) |=> !lv_hit); // R8

  AST_UV_LATCHED: assert property (@(posedge clk) disable iff (por_pulse)
    lv_detect |=> uv_flag); // R9

endmodule

bind rst_supervisor rsv_checker #(.TIMEOUT(TIMEOUT), .RST_CYC(RST_CYC)) u_chk (
  .clk(clk), .ext_rst_n(ext_rst_n), .por_pulse(por_pulse), .lv_detect(lv_detect),
  .sys_rst(sys_rst), .port_clr(port_clr), .feed_ok(feed_ok),
  .wd_expire(wd_expire), .wd_busy(wd_busy), .wd_cnt(wd_cnt), .lv_hit(lv_hit),
  .lv_en(ctrl_act.lv_en), .wd_run(ctrl_act.wd_run), .uv_flag(uv_flag)
);

// File: tb/rst_supervisor_tb.sv
`timescale 1ns/100ps
module rst_supervisor_tb;

  localparam int T  = 64;
  localparam int RC = 16;
  localparam int NV = 18;

  logic       clk = 1'b0;
  logic       ext_rst_n = 1'b0;
  logic       por_pulse = 1'b1;
  logic       lv_detect = 1'b0;
  logic [1:0] bus_addr  = '0;
  logic [7:0] bus_wdata = '0;
  logic       bus_we    = 1'b0;
  logic [7:0] bus_rdata;
  logic       sys_rst, port_clr;

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  always #2 clk = ~clk;

  rst_supervisor #(.ADDR_W(2), .TIMEOUT(T), .RST_CYC(RC)) u_dut (
    .clk(clk), .ext_rst_n(ext_rst_n), .por_pulse(por_pulse), .lv_detect(lv_detect),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .sys_rst(sys_rst), .port_clr(port_clr)
  );

  // {we, addr[1:0], data[7:0], expected read[7:0]}
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'd0, 8'h00, 8'h00},  // stage run=0 enable=0
    {1'b0, 2'd0, 8'h00, 8'h14},  // not yet committed
    {1'b1, 2'd1, 8'hA5, 8'h00},
    {1'b1, 2'd2, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00},  // committed
    {1'b1, 2'd0, 8'h14, 8'h00},
    {1'b1, 2'd1, 8'hA5, 8'h00},
    {1'b1, 2'd3, 8'hFF, 8'h00},  // foreign write aborts
    {1'b1, 2'd2, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'hA6, 8'h00},  // wrong first key
    {1'b1, 2'd2, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00},
    {1'b1, 2'd1, 8'hA5, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h00},  // a read between keys is not a write
    {1'b1, 2'd2, 8'h5A, 8'h00},
    {1'b0, 2'd0, 8'h00, 8'h14},
    {1'b0, 2'd3, 8'h00, 8'h10}   // written ones left flags as they were
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input string req, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    #0.5;
    check(req, bus_rdata, exp);
  endtask

  task automatic feed();
    wr(2'd1, 8'hA5);
    wr(2'd2, 8'h5A);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    // Reset state (R11, R4, R9)
    #5;
    check("R11 reset asserts sys_rst", {7'd0, sys_rst}, 8'd1);
    check("R11 reset asserts port_clr", {7'd0, port_clr}, 8'd1);
    por_pulse = 1'b0;
    repeat (3) @(negedge clk);
    ext_rst_n = 1'b1;
    #0.5;
    check("R11 release", {7'd0, sys_rst}, 8'd0);
    rd("R4 ctrl after power-on", 2'd0, 8'h14);
    rd("R9 power-on flag set", 2'd3, 8'h10);

    // Vector table (R1 R2 R3)
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][18]) wr(VEC[i][17:16], VEC[i][15:8]);
      else rd($sformatf("R1 R2 R3 table step %0d", i), VEC[i][17:16], VEC[i][7:0]);
    end

    // R10 clear by writing zero
    wr(2'd3, 8'h00);
    rd("R10 power-on flag cleared", 2'd3, 8'h00);

    // R8: disable undervoltage reset, pulse comparator
    wr(2'd0, 8'h04);
    feed();
    rd("R3 ctrl committed 04", 2'd0, 8'h04);
    @(negedge clk); lv_detect = 1'b1;
    @(negedge clk); lv_detect = 1'b0;
    #0.5;
    check("R8 no reset when disabled", {7'd0, sys_rst}, 8'd0);
    rd("R9 undervoltage flag set while disabled", 2'd3, 8'h20);

    // R5 expiry timing, R11 write ignored during reset
    feed();
    repeat (T - 1) @(negedge clk);
    #0.5;
    check("R5 no reset one edge before timeout", {7'd0, sys_rst}, 8'd0);
    @(negedge clk); #0.5;
    check("R5 reset at timeout", {7'd0, sys_rst}, 8'd1);
    wr(2'd3, 8'h00);
    repeat (RC - 3) @(negedge clk);
    #0.5;
    check("R5 reset still held at last cycle", {7'd0, sys_rst}, 8'd1);
    @(negedge clk); #0.5;
    check("R5 reset released after RST_CYC", {7'd0, sys_rst}, 8'd0);
    rd("R4 ctrl restored after watchdog reset", 2'd0, 8'h14);
    rd("R10 R11 flag survives warm reset and ignored write", 2'd3, 8'h20);

    // R7 undervoltage reset
    @(negedge clk); lv_detect = 1'b1;
    @(negedge clk); #0.5;
    check("R7 undervoltage reset asserted", {7'd0, sys_rst}, 8'd1);
    check("R11 port_clr during undervoltage reset", {7'd0, port_clr}, 8'd1);
    repeat (2) @(negedge clk);
    lv_detect = 1'b0;
    @(negedge clk); #0.5;
    check("R7 undervoltage reset released", {7'd0, sys_rst}, 8'd0);
    rd("R4 ctrl after undervoltage reset", 2'd0, 8'h14);

    // R6 stopped watchdog
    wr(2'd0, 8'h10);
    feed();
    begin
      int hits = 0;
      for (int k = 0; k < 3 * T; k++) begin
        @(negedge clk); #0.5;
        if (sys_rst) hits++;
      end
      check("R6 stopped watchdog never resets", hits[7:0], 8'd0);
    end

    // R1 idle cycle between keys
    wr(2'd0, 8'h14);
    wr(2'd1, 8'hA5);
    @(negedge clk);
    wr(2'd2, 8'h5A);
    rd("R1 feed with idle gap commits", 2'd0, 8'h14);

    // R11 asynchronous port clear from the pin
    @(negedge clk); #0.5;
    ext_rst_n = 1'b0;
    #0.5;
    check("R11 port_clr from pin without edge", {7'd0, port_clr}, 8'd1);
    #0.5; ext_rst_n = 1'b1;
    #0.2;

    // R9 power-on pulse between edges
    @(negedge clk); #0.5;
    por_pulse = 1'b1;
    #0.5;
    check("R11 port_clr from power-on without edge", {7'd0, port_clr}, 8'd1);
    #0.5; por_pulse = 1'b0;
    rd("R9 power-on sets flag and clears undervoltage", 2'd3, 8'h10);
    rd("R4 ctrl after power-on pulse", 2'd0, 8'h14);

    done = 1;
    finish_run();
  end

endmodule